// File: doc/BRIEF.md
# Routable Maskable Interrupt Controller

This block collects interrupt requests from eight on-chip peripheral sources and two external pins. Each request sets a sticky pending bit on its rising edge. Software reads the pending bits directly to find the cause. Each bit is gated by an enable bit. A steering bit then sends each enabled pending source to one of two level interrupt request lines of a microcontroller core. A single-cycle wake pulse marks the moment the first enabled interrupt appears, so an idle core can resume.

Software reaches three ten-bit registers over a byte-wide bus: pending, enable and steering. The low byte of each register sits at its base address. The two upper bits sit at the base address plus 0x10. Writes take effect on the clock edge. Reads are combinational and are valid while the read strobe is high.

Top module: `irqRouter`

## Requirements
- R1: After reset the pending, enable and steering registers are all zero, both request lines and the wake pulse are low, and every register reads 0.
- R2: The pending register is read at 0xFE04, the enable register at 0xFE0D and the steering register at 0xFE0E; bits 9:8 of each are at base+0x10 in data bits 1:0, and data bits 7:2 of those upper bytes read 0. Source index i maps to bit i: 0 SCSI, 1 DMA, 2 and 3 two-wire serial, 4 timer 1, 5 timer 2, 6 and 7 backplane ports (periphReq[7:0]), 8 and 9 external pins (extPin[1:0]).
- R3: A 0-to-1 transition of periphReq[i] sets pending bit i at the next clock edge; a request held high does not set the bit again after it has been cleared.
- R4: An external pin passes through a two-flop synchronizer and a rising-edge detector: a pin that goes high before clock edge 1 sets its pending bit at edge 3 and not before.
- R5: Writing 1 to a pending bit clears it; writing 0 leaves it unchanged. Writes to the enable and steering registers load the written value.
- R6: If a new rising edge and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R7: A pending bit whose enable bit is 0 drives neither request line, but it stays readable in the pending register.
- R8: irqLine0 is high while any source is pending, enabled and has steering bit 0; irqLine1 is high while any source is pending, enabled and has steering bit 1.
- R9: wakePulse is high for exactly one cycle, in the first cycle in which at least one request line is high after a cycle in which both were low.
- R10: busRdata is 0 while busRe is low and when an address outside the six mapped bytes is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Byte address of the register access |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, acts on the clock edge |
| busRe | input | 1 | Read strobe, selects combinational read data |
| busRdata | output | 8 | Read data |
| periphReq | input | 8 | On-chip peripheral request lines (sources 0..7) |
| extPin | input | 2 | Asynchronous external interrupt pins (sources 8, 9) |
| irqLine0 | output | 1 | Level interrupt request, line 0 |
| irqLine1 | output | 1 | Level interrupt request, line 1 |
| wakePulse | output | 1 | One-cycle wake indication |

## Verification
The assertions check four things on every cycle. The wake pulse never lasts more than one cycle and only appears while a request line is high. Read data stays zero without a read strobe or at an unmapped address. The spare upper bits of the high bytes always read zero. The bench's scenarios are needed for the ordering effects: edge-versus-level latching of requests, the three-edge latency of the external pins, a clear losing to a simultaneous new edge, and masked sources that stay visible in the pending register but stay off both lines. A behavioural model compared on every clock covers random mixes of requests, writes and reads.

// File: rtl/irqRouterPkg.sv
package irqRouterPkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT_LO,
    SEL_STAT_HI,
    SEL_MASK_LO,
    SEL_MASK_HI,
    SEL_DEST_LO,
    SEL_DEST_HI
  } regSel_e;

  typedef struct packed {
    logic    clrStatLo;
    logic    clrStatHi;
    logic    wrMaskLo;
    logic    wrMaskHi;
    logic    wrDestLo;
    logic    wrDestHi;
    regSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqRouterPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hFE0D,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'hFE0E,
  parameter logic [ADDR_W-1:0] HI_OFS    = 16'h0010
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output busStrobe_t        stb
);

  regSel_e hitSel;

  always_comb begin
    if      (busAddr == STAT_ADDR)          hitSel = SEL_STAT_LO;
    else if (busAddr == STAT_ADDR + HI_OFS) hitSel = SEL_STAT_HI;
    else if (busAddr == MASK_ADDR)          hitSel = SEL_MASK_LO;
    else if (busAddr == MASK_ADDR + HI_OFS) hitSel = SEL_MASK_HI;
    else if (busAddr == DEST_ADDR)          hitSel = SEL_DEST_LO;
    else if (busAddr == DEST_ADDR + HI_OFS) hitSel = SEL_DEST_HI;
    else                                    hitSel = SEL_NONE;
  end

  always_comb begin
    stb.clrStatLo = busWe && (hitSel == SEL_STAT_LO);
    stb.clrStatHi = busWe && (hitSel == SEL_STAT_HI);
    stb.wrMaskLo  = busWe && (hitSel == SEL_MASK_LO);
    stb.wrMaskHi  = busWe && (hitSel == SEL_MASK_HI);
    stb.wrDestLo  = busWe && (hitSel == SEL_DEST_LO);
    stb.wrDestHi  = busWe && (hitSel == SEL_DEST_HI);
    stb.rdSel     = busRe ? hitSel : SEL_NONE;
  end

endmodule

// File: rtl/irqDp.sv
module irqDp
  import irqRouterPkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_EXT    = 2,
  parameter int DATA_W     = 8,
  parameter int SYNC_LEN   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobe_t            stb,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_EXT-1:0]    extPin,
  output logic [DATA_W-1:0]     busRdata,
  output logic [1:0]            irqLine,
  output logic                  wakePulse
);

  localparam int NS   = NUM_PERIPH + NUM_EXT;
  localparam int HI_W = NS - DATA_W;
  localparam int PIPE = SYNC_LEN + 1;

  logic [NS-1:0]         statusQ, statusD;
  logic [NS-1:0]         maskQ, maskD;
  logic [NS-1:0]         destQ, destD;
  logic [NS-1:0]         clrVec, riseVec, pendEn;
  logic [NUM_PERIPH-1:0] reqPrevQ;
  logic [NUM_EXT-1:0]    extRise;
  logic                  anyQ;

  // external pins: synchronizer stages followed by one history stage
  for (genvar g = 0; g < NUM_EXT; g++) begin : gExt
    logic [PIPE-1:0] pipeQ;
    always_ff @(posedge clk) begin
      if (!rstN) pipeQ <= '0;
      else       pipeQ <= {pipeQ[PIPE-2:0], extPin[g]};
    end
    assign extRise[g] = pipeQ[PIPE-2] & ~pipeQ[PIPE-1];
  end

  assign riseVec = {extRise, periphReq & ~reqPrevQ};

  always_comb begin
    clrVec = '0;
    if (stb.clrStatLo) clrVec[DATA_W-1:0] = busWdata;
    if (stb.clrStatHi) clrVec[NS-1:DATA_W] = busWdata[HI_W-1:0];
    statusD = (statusQ & ~clrVec) | riseVec;
  end

  always_comb begin
    maskD = maskQ;
    destD = destQ;
    if (stb.wrMaskLo) maskD[DATA_W-1:0]  = busWdata;
    if (stb.wrMaskHi) maskD[NS-1:DATA_W] = busWdata[HI_W-1:0];
    if (stb.wrDestLo) destD[DATA_W-1:0]  = busWdata;
    if (stb.wrDestHi) destD[NS-1:DATA_W] = busWdata[HI_W-1:0];
  end

  assign pendEn = statusQ & maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      maskQ    <= '0;
      destQ    <= '0;
      reqPrevQ <= '0;
      anyQ     <= 1'b0;
    end else begin
      statusQ  <= statusD;
      maskQ    <= maskD;
      destQ    <= destD;
      reqPrevQ <= periphReq;
      anyQ     <= |pendEn;
    end
  end

  assign irqLine[0] = |(pendEn & ~destQ);
  assign irqLine[1] = |(pendEn & destQ);
  assign wakePulse  = (|pendEn) & ~anyQ;

  always_comb begin
    unique case (stb.rdSel)
      SEL_STAT_LO: busRdata = statusQ[DATA_W-1:0];
      SEL_STAT_HI: busRdata = DATA_W'(statusQ[NS-1:DATA_W]);
      SEL_MASK_LO: busRdata = maskQ[DATA_W-1:0];
      SEL_MASK_HI: busRdata = DATA_W'(maskQ[NS-1:DATA_W]);
      SEL_DEST_LO: busRdata = destQ[DATA_W-1:0];
      SEL_DEST_HI: busRdata = DATA_W'(destQ[NS-1:DATA_W]);
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/irqRouter.sv
module irqRouter
  import irqRouterPkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_EXT    = 2,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hFE0D,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'hFE0E,
  parameter logic [ADDR_W-1:0] HI_OFS    = 16'h0010
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  busWe,
  input  logic                  busRe,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_EXT-1:0]    extPin,
  output logic                  irqLine0,
  output logic                  irqLine1,
  output logic                  wakePulse
);

  busStrobe_t stb;
  logic [1:0] irqLine;

  irqCtrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR),
    .DEST_ADDR(DEST_ADDR), .HI_OFS(HI_OFS)
  ) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .stb(stb)
  );

  irqDp #(
    .NUM_PERIPH(NUM_PERIPH), .NUM_EXT(NUM_EXT), .DATA_W(DATA_W), .SYNC_LEN(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .periphReq(periphReq), .extPin(extPin), .busRdata(busRdata),
    .irqLine(irqLine), .wakePulse(wakePulse)
  );

  assign irqLine0 = irqLine[0];
  assign irqLine1 = irqLine[1];

endmodule

// File: rtl/irqRouterChk.sv
module irqRouterChk #(
  parameter int NUM_SRC = 10,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hFE0D,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'hFE0E,
  parameter logic [ADDR_W-1:0] HI_OFS    = 16'h0010
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRe,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqLine0,
  input logic              irqLine1,
  input logic              wakePulse
);

  localparam int HI_W = NUM_SRC - DATA_W;

  logic hiHit, anyHit;
  assign hiHit = (busAddr == STAT_ADDR + HI_OFS) || (busAddr == MASK_ADDR + HI_OFS) ||
                 (busAddr == DEST_ADDR + HI_OFS);
  assign anyHit = hiHit || (busAddr == STAT_ADDR) || (busAddr == MASK_ADDR) ||
                  (busAddr == DEST_ADDR);

  // R9
  wake_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R9
  wake_with_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (irqLine0 || irqLine1));

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |-> (busRdata == '0));

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !anyHit) |-> (busRdata == '0));

  // R2
  hi_spare_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && hiHit) |-> (busRdata[DATA_W-1:HI_W] == '0));

endmodule

bind irqRouter irqRouterChk #(
  .NUM_SRC(NUM_PERIPH + NUM_EXT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR), .DEST_ADDR(DEST_ADDR), .HI_OFS(HI_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRe(busRe), .busRdata(busRdata),
  .irqLine0(irqLine0), .irqLine1(irqLine1), .wakePulse(wakePulse)
);

// File: tb/irqRouter_tb.sv
`timescale 1ns/1ps
module irqRouter_tb;

  localparam logic [15:0] STAT = 16'hFE04;
  localparam logic [15:0] MASK = 16'hFE0D;
  localparam logic [15:0] DEST = 16'hFE0E;
  localparam logic [15:0] HI   = 16'h0010;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [7:0]  busRdata;
  logic [7:0]  periphReq = '0;
  logic [1:0]  extPin = '0;
  logic        irqLine0, irqLine1, wakePulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  int mStat, mMask, mDest, mPrev, mAnyPrev;
  int mSync[$];
  int lastRd, lastL0, lastL1, lastWake;

  irqRouter u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata), .periphReq(periphReq),
    .extPin(extPin), .irqLine0(irqLine0), .irqLine1(irqLine1), .wakePulse(wakePulse)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int modelRead(input logic [15:0] a, input bit re);
    if (!re) return 0;
    if (a == STAT)      return mStat & 8'hFF;
    if (a == STAT + HI) return (mStat >> 8) & 3;
    if (a == MASK)      return mMask & 8'hFF;
    if (a == MASK + HI) return (mMask >> 8) & 3;
    if (a == DEST)      return mDest & 8'hFF;
    if (a == DEST + HI) return (mDest >> 8) & 3;
    return 0;
  endfunction

  function automatic int lineOf(input int k);
    int en;
    en = mStat & mMask;
    if (k == 0) return ((en & ~mDest & 16'h3FF) != 0) ? 1 : 0;
    return ((en & mDest) != 0) ? 1 : 0;
  endfunction

  function automatic int loadByte(input int reg_, input bit hi, input int d);
    if (hi) return (reg_ & 8'hFF) | ((d & 3) << 8);
    return (reg_ & 16'h300) | (d & 8'hFF);
  endfunction

  task automatic modelReset();
    mStat = 0; mMask = 0; mDest = 0; mPrev = 0; mAnyPrev = 0;
    mSync.delete();
    for (int i = 0; i < 3; i++) mSync.push_back(0);
  endtask

  // one bus cycle: drive, compare against the model, clock, update the model
  task automatic step(input logic [15:0] a, input logic [7:0] d, input bit we, input bit re);
    int l0, l1, rise, clr, s2, s3, any;
    busAddr = a; busWdata = d; busWe = we; busRe = re;
    #2;
    l0 = lineOf(0); l1 = lineOf(1);
    any = l0 | l1;
    lastRd = int'(busRdata); lastL0 = int'(irqLine0); lastL1 = int'(irqLine1);
    lastWake = int'(wakePulse);
    chk("R8 line0", lastL0, l0);
    chk("R8 line1", lastL1, l1);
    chk("R9 wake", lastWake, (any != 0 && mAnyPrev == 0) ? 1 : 0);
    chk("R2 rdata", lastRd, modelRead(a, re));
    @(posedge clk);
    s2 = mSync[1]; s3 = mSync[2];
    rise = (int'(periphReq) & ~mPrev & 8'hFF) | ((s2 & ~s3 & 3) << 8);
    clr = 0;
    if (we && a == STAT)      clr = d;
    if (we && a == STAT + HI) clr = (d & 3) << 8;
    mStat = (mStat & ~clr) | rise;
    if (we && a == MASK)      mMask = loadByte(mMask, 0, d);
    if (we && a == MASK + HI) mMask = loadByte(mMask, 1, d);
    if (we && a == DEST)      mDest = loadByte(mDest, 0, d);
    if (we && a == DEST + HI) mDest = loadByte(mDest, 1, d);
    mPrev = int'(periphReq);
    mAnyPrev = any;
    void'(mSync.pop_back());
    mSync.push_front(int'(extPin));
    @(negedge clk);
  endtask

  task automatic idle();
    step(16'h0000, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    step(STAT, 0, 0, 1);      chk("R1 stat lo", lastRd, 0);
    step(STAT + HI, 0, 0, 1); chk("R1 stat hi", lastRd, 0);
    step(MASK, 0, 0, 1);      chk("R1 mask lo", lastRd, 0);
    step(MASK + HI, 0, 0, 1); chk("R1 mask hi", lastRd, 0);
    step(DEST, 0, 0, 1);      chk("R1 dest lo", lastRd, 0);
    step(DEST + HI, 0, 0, 1); chk("R1 dest hi", lastRd, 0);
    chk("R1 lines", lastL0 | lastL1 | lastWake, 0);

    // R5 / R2: enable every source and read back
    step(MASK, 8'hFF, 1, 0);
    step(MASK + HI, 8'hFF, 1, 0);
    step(MASK, 0, 0, 1);      chk("R5 mask lo", lastRd, 8'hFF);
    step(MASK + HI, 0, 0, 1); chk("R2 mask hi spare bits", lastRd, 8'h03);

    // R3 / R9: a pulse on SCSI request
    periphReq = 8'h01;
    idle();
    periphReq = 8'h00;
    step(STAT, 0, 0, 1);
    chk("R3 edge sets", lastRd, 8'h01);
    chk("R9 wake high", lastWake, 1);
    chk("R8 line0 high", lastL0, 1);
    idle();
    chk("R9 wake one cycle", lastWake, 0);

    // R3: held level does not re-set
    periphReq = 8'h10;
    idle();
    step(STAT, 8'h10, 1, 0);
    step(STAT, 0, 0, 1);
    chk("R3 held level", lastRd, 8'h01);

    // R5: write 0 no effect, write 1 clears
    step(STAT, 8'h00, 1, 0);
    step(STAT, 0, 0, 1);      chk("R5 write zero", lastRd, 8'h01);
    step(STAT, 8'h01, 1, 0);
    step(STAT, 0, 0, 1);      chk("R5 write one clears", lastRd, 8'h00);

    // R6: rise and clear in the same cycle
    periphReq = 8'h14;
    step(STAT, 8'h04, 1, 0);
    periphReq = 8'h00;
    step(STAT, 0, 0, 1);      chk("R6 set wins", lastRd, 8'h04);

    // R8: steer bit 2 to line 1
    step(DEST, 8'h04, 1, 0);
    idle();
    chk("R8 steer line1", lastL1, 1);
    chk("R8 steer line0 low", lastL0, 0);
    step(STAT, 8'h04, 1, 0);

    // R4: external pin 1 latency
    extPin = 2'b10;
    idle();
    idle();
    step(STAT + HI, 0, 0, 1); chk("R4 not before edge 3", lastRd, 0);
    step(STAT + HI, 0, 0, 1); chk("R4 set at edge 3", lastRd, 2);
    extPin = 2'b00;

    // R7: disable all sources
    step(MASK, 8'h00, 1, 0);
    step(MASK + HI, 8'h00, 1, 0);
    idle();
    chk("R7 lines masked", lastL0 | lastL1, 0);
    step(STAT + HI, 0, 0, 1); chk("R7 still pending", lastRd, 2);

    // R10: reads outside the map or without strobe
    step(16'h1234, 0, 0, 1);  chk("R10 unmapped", lastRd, 0);
    step(STAT + HI, 0, 0, 0); chk("R10 no strobe", lastRd, 0);

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      int pick;
      pick = $urandom_range(0, 6);
      case (pick)
        0: a = STAT;      1: a = STAT + HI;
        2: a = MASK;      3: a = MASK + HI;
        4: a = DEST;      5: a = DEST + HI;
        default: a = 16'hFE05;
      endcase
      periphReq = 8'($urandom);
      extPin = 2'($urandom);
      step(a, 8'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule